// File: doc/BRIEF.md
# Reset Cause Capture Register

This block holds one byte that records why the system last went through reset, so that host software can find out after the fact. Four sticky flags each catch a one-cycle pulse from a reset source: the management controller, a front-panel button, a backplane reset input and the watchdog timer. A fifth sticky flag marks a cold power-on. The host clears any of these by writing a 1 to its bit.

A sixth bit is a handshake between the host and the management controller. The host sets it to ask that the coming reset go unlogged. The host cannot clear it; only the controller's clear input can.

The host reaches the byte through a simple read/write strobe port at one address. Contents return to their defaults only on power-on reset. The system reset input touches only the read-data output, so the cause can still be read once that reset has finished.

Top module: `reset_cause_reg`

## Requirements
- R1: While `por_n` is low, the byte is forced to 0x80: the power-on flag (bit 7) is 1 and every other bit is 0. After release, a read returns 0x80.
- R2: Bits 6 and 4 always read 0. A host write to them has no effect.
- R3: A host write to the register address clears each of bits 7, 3, 2, 1 and 0 whose write-data bit is 1. Bits written with 0 keep their value.
- R4: A one-cycle pulse sets its bit on the next clock edge: `src_mgmt` sets bit 3, `src_panel` sets bit 2, `src_backplane` sets bit 1 and `src_wdog` sets bit 0. The bit stays set until it is cleared.
- R5: When a source pulse and a host write-1-to-clear of the same bit occur in the same cycle, the bit ends as 1.
- R6: A host write with data bit 5 at 1 sets the do-not-log flag (bit 5). A host write with data bit 5 at 0 leaves bit 5 unchanged.
- R7: `mgmt_clr_nolog` clears bit 5 on the next edge. If a host set of bit 5 happens in the same cycle, the set wins.
- R8: `sys_rst` does not change any register bit. While `sys_rst` is high, `host_rdata` is driven to 0.
- R9: A read strobe to the register address puts the byte on `host_rdata` one cycle later. In every other cycle `host_rdata` is 0. A read has no side effects.
- R10: A host write or read whose address differs from `REG_ADDR` (default 0x285) does not affect the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst | input | 1 | Synchronous system reset; clears only the read-data output |
| host_addr | input | ADDR_W | Host byte address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data |
| mgmt_clr_nolog | input | 1 | Management controller clear of the do-not-log flag |
| src_mgmt | input | 1 | Management controller reset pulse |
| src_panel | input | 1 | Front-panel button reset pulse |
| src_backplane | input | 1 | Backplane reset input pulse |
| src_wdog | input | 1 | Watchdog reset pulse |

## Verification
The bench checks a clear and a source pulse that land on the same bit in the same cycle. A design that let the clear win would lose a reset cause. It also tries a host write of 0 to the do-not-log bit. A design that treated bit 5 like a normal read/write bit would clear the request when the host should not be able to.

It raises the controller clear in the same cycle as a host set. It also asserts the system reset while the flags are set; a design that reset its contents there would read back 0x00 instead of the cause. Finally, it writes the whole byte to a neighbouring address and to the reserved bits. A design with a loose address decode, or with storage behind the reserved bits, would show changed read data.

// File: rtl/reset_cause_reg.sv
module reset_cause_reg #(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0285
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic              mgmt_clr_nolog,
  input  logic              src_mgmt,
  input  logic              src_panel,
  input  logic              src_backplane,
  input  logic              src_wdog
);
  logic       cold_q, nolog_q;
  logic [3:0] cause_q;
  logic [3:0] src_vec;
  logic       hit, wr_hit, rd_hit;
  logic [7:0] view;

  assign hit     = (host_addr == REG_ADDR);
  assign wr_hit  = host_wr && hit;
  assign rd_hit  = host_rd && hit;
  assign src_vec = {src_mgmt, src_panel, src_backplane, src_wdog};
  assign view    = {cold_q, 1'b0, nolog_q, 1'b0, cause_q};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cold_q  <= 1'b1;
      nolog_q <= 1'b0;
      cause_q <= '0;
    end else begin
      if (wr_hit && host_wdata[7]) cold_q <= 1'b0;
      if (wr_hit && host_wdata[5]) nolog_q <= 1'b1;
      else if (mgmt_clr_nolog)     nolog_q <= 1'b0;
      cause_q <= (cause_q & ~(wr_hit ? host_wdata[3:0] : 4'h0)) | src_vec;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       host_rdata <= '0;
    else if (sys_rst) host_rdata <= '0;
    else              host_rdata <= rd_hit ? view : 8'h00;
  end

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!por_n)
    (host_rdata[6] == 1'b0) && (host_rdata[4] == 1'b0));

  p_src_set_r4: assert property (@(posedge clk) disable iff (!por_n)
    src_wdog |=> cause_q[0]);

  p_src_wins_r5: assert property (@(posedge clk) disable iff (!por_n)
    (src_backplane && wr_hit && host_wdata[1]) |=> cause_q[1]);

  p_nolog_set_r6: assert property (@(posedge clk) disable iff (!por_n)
    (wr_hit && host_wdata[5]) |=> nolog_q);

  p_nolog_host_keep_r6: assert property (@(posedge clk) disable iff (!por_n)
    (nolog_q && !mgmt_clr_nolog) |=> nolog_q);

  p_mgmt_clr_r7: assert property (@(posedge clk) disable iff (!por_n)
    (mgmt_clr_nolog && !(wr_hit && host_wdata[5])) |=> !nolog_q);

  p_sysrst_keep_r8: assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst && !host_wr && !mgmt_clr_nolog && (src_vec == 4'h0)) |=> $stable(view));

  p_read_lat_r9: assert property (@(posedge clk) disable iff (!por_n)
    (rd_hit && !sys_rst) |=> (host_rdata == $past(view)));

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!por_n)
    !rd_hit |=> (host_rdata == 8'h00));
endmodule

// File: tb/tb_reset_cause_reg.sv
module tb_reset_cause_reg;
  localparam logic [15:0] A = 16'h0285;
  logic clk = 0, por_n = 0, sys_rst = 0;
  logic [15:0] host_addr = A;
  logic host_wr = 0, host_rd = 0, mgmt_clr_nolog = 0;
  logic [7:0] host_wdata = 0, host_rdata;
  logic src_mgmt = 0, src_panel = 0, src_backplane = 0, src_wdog = 0;
  int tests = 0, fails = 0;
  string phase = "R1";
  logic [7:0] m_reg, m_rd;

  always #2 clk = ~clk;

  reset_cause_reg dut (.clk(clk), .por_n(por_n), .sys_rst(sys_rst), .host_addr(host_addr),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mgmt_clr_nolog(mgmt_clr_nolog), .src_mgmt(src_mgmt), .src_panel(src_panel),
    .src_backplane(src_backplane), .src_wdog(src_wdog));

  // behavioural reference
  always @(posedge clk or negedge por_n) begin
    logic [7:0] n;
    if (!por_n) begin m_reg = 8'h80; m_rd = 8'h00; end
    else begin
      n = m_reg;
      if (mgmt_clr_nolog) n[5] = 1'b0;
      if (host_wr && host_addr == A) begin
        n = n & ~(host_wdata & 8'h8F);
        if (host_wdata[5]) n[5] = 1'b1;
      end
      n = n | {4'h0, src_mgmt, src_panel, src_backplane, src_wdog};
      m_rd = sys_rst ? 8'h00 : ((host_rd && host_addr == A) ? m_reg : 8'h00);
      m_reg = n;
    end
  end

  always @(negedge clk) if (por_n) begin
    tests++;
    if (host_rdata !== m_rd) begin
      fails++;
      $display("FAIL %s cycle compare: got %02h expected %02h", phase, host_rdata, m_rd);
    end
  end

  task automatic idle();
    host_wr = 0; host_rd = 0; mgmt_clr_nolog = 0; host_addr = A;
    src_mgmt = 0; src_panel = 0; src_backplane = 0; src_wdog = 0;
  endtask

  task automatic step();
    @(negedge clk); idle();
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    host_addr = a; host_wdata = d; host_wr = 1; step();
  endtask

  task automatic rd_chk(input logic [7:0] exp, input string tag);
    phase = tag;
    host_rd = 1; host_addr = A; @(negedge clk);
    tests++;
    if (host_rdata !== exp) begin
      fails++;
      $display("FAIL %s read: got %02h expected %02h", tag, host_rdata, exp);
    end
    idle();
  endtask

  initial begin
    fork
      begin
        #800000;
        fails++; tests++;
        $display("FAIL watchdog: got hang expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    por_n = 1; step();
    rd_chk(8'h80, "R1");
    wr(A, 8'h00); rd_chk(8'h80, "R3");
    wr(A, 8'h80); rd_chk(8'h00, "R3");
    src_wdog = 1; step(); rd_chk(8'h01, "R4");
    src_backplane = 1; step(); rd_chk(8'h03, "R4");
    src_panel = 1; step(); rd_chk(8'h07, "R4");
    src_mgmt = 1; step(); rd_chk(8'h0F, "R4");
    wr(A, 8'h05); rd_chk(8'h0A, "R3");
    wr(A, 8'h50); rd_chk(8'h0A, "R2");
    src_backplane = 1; wr(A, 8'h0A); rd_chk(8'h02, "R5");
    wr(A, 8'h20); rd_chk(8'h22, "R6");
    wr(A, 8'h00); rd_chk(8'h22, "R6");
    wr(A, 8'hDF); rd_chk(8'h20, "R6");
    mgmt_clr_nolog = 1; step(); rd_chk(8'h00, "R7");
    mgmt_clr_nolog = 1; wr(A, 8'h20); rd_chk(8'h20, "R7");
    mgmt_clr_nolog = 1; step(); rd_chk(8'h00, "R7");
    src_wdog = 1; step();
    phase = "R8"; sys_rst = 1; host_rd = 1; @(negedge clk);
    tests++;
    if (host_rdata !== 8'h00) begin
      fails++; $display("FAIL R8 read in reset: got %02h expected 00", host_rdata);
    end
    idle(); step(); sys_rst = 0; step();
    rd_chk(8'h01, "R8");
    wr(16'h0284, 8'hFF); rd_chk(8'h01, "R10");
    phase = "R9"; host_rd = 1; host_addr = 16'h0284; @(negedge clk);
    tests++;
    if (host_rdata !== 8'h00) begin
      fails++; $display("FAIL R9 off-address read: got %02h expected 00", host_rdata);
    end
    idle();
    rd_chk(8'h01, "R9"); rd_chk(8'h01, "R9");
    por_n = 0; step(); por_n = 1; step();
    rd_chk(8'h80, "R1");
    step();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule